// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block generates one delayed pulse per trigger. A trigger comes either from a selected edge on an asynchronous trigger pin or from a one-cycle software strobe. A valid trigger clears the counter to zero and starts it. The counter then advances once per cycle in which the count-enable input is high. That input stands in for a prescaled clock.

Two compare values place the pulse. The output turns active at the smaller value and returns to idle at the larger one, whichever register holds which. When the larger value is reached, the counter stops and holds its value. The block then re-arms and accepts the next trigger. While a pulse sequence is running, every new trigger is ignored. Each compare register drives its own one-cycle match strobe. A polarity input sets the idle level of the output.

Top module: `pulse_timer`

## Requirements
- R1: While reset is high and at the first sample after reset: count is 0, busy is 0, both match strobes are 0 and pulse_out equals idle_level.
- R2: The trigger pin passes through two synchronizer flops before edge detection. edge_sel 00 accepts no pin edge, 01 accepts rising edges, 10 accepts falling edges and 11 accepts both. A level change applied before clock edge k sets busy after edge k+2, and not earlier.
- R3: An accepted trigger sets count to 0 and busy to 1 at the next edge. After that, count rises by one on every edge where cnt_en is high.
- R4: mode 00 stops the block: count clears to 0, busy drops and the output returns to idle. mode 01 accepts pin triggers only, 10 accepts software triggers only, and 11 accepts both.
- R5: On an edge where cnt_en is high and count equals the smaller compare value, pulse_out becomes the inverse of idle_level.
- R6: The smaller of cmp_a and cmp_b always starts the pulse and the larger always ends it, whichever register holds which. Equal values are not allowed.
- R7: match_a (match_b) is high for exactly one cycle after an edge where busy and cnt_en are high and count equals cmp_a (cmp_b). It is never high in two consecutive cycles.
- R8: A trigger of either source that arrives while busy is high has no effect on count, busy or pulse_out.
- R9: On an edge where cnt_en is high and count equals the larger compare value, busy drops, pulse_out returns to idle_level and count holds that value. The next accepted trigger then starts a new pulse.
- R10: pulse_out equals idle_level whenever no pulse is active. idle_level 1 gives an active-low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode: 00 stop, 01 pin, 10 software, 11 both |
| edge_sel | input | 2 | Accepted pin edge: 00 none, 01 rising, 10 falling, 11 both |
| sw_trig | input | 1 | Software trigger strobe, one cycle |
| trig_in | input | 1 | Asynchronous trigger pin |
| cnt_en | input | 1 | Count enable (prescaled tick) |
| cmp_a | input | CNT_W | First compare value |
| cmp_b | input | CNT_W | Second compare value |
| idle_level | input | 1 | Output level when no pulse is active |
| pulse_out | output | 1 | Pulse output |
| match_a | output | 1 | One-cycle strobe on cmp_a match |
| match_b | output | 1 | One-cycle strobe on cmp_b match |
| busy | output | 1 | Pulse sequence in progress |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two synchronizer stages. With those values the exact three-edge pin latency can be checked, and a directed run from 0 to 16'hFFFF reaches the top compare value without the counter wrapping. Random episodes keep the compare values small so that many complete pulses fit in the run. Those episodes mix both compare orders, gaps in count-enable, retriggers while busy and stop writes in the middle of a pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_PIN  = 2'b01,
        MODE_SOFT = 2'b10,
        MODE_ANY  = 2'b11
    } os_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    typedef struct packed {
        logic run;
        logic active;
    } core_flags_t;

    // edge_sel bit 0 accepts rising edges, bit 1 accepts falling edges
    function automatic logic edge_hit(input logic [1:0] sel, input edge_ev_t ev);
        return (sel[0] & ev.rise) | (sel[1] & ev.fall);
    endfunction

    function automatic logic pin_allowed(input os_mode_e m);
        return (m == MODE_PIN) || (m == MODE_ANY);
    endfunction

    function automatic logic soft_allowed(input os_mode_e m);
        return (m == MODE_SOFT) || (m == MODE_ANY);
    endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output edge_ev_t ev
);
    localparam int LAST = STAGES;

    // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[LAST-1:0], din};
    end

    always_comb begin
        ev.rise = sh[LAST-1] & ~sh[LAST];
        ev.fall = ~sh[LAST-1] & sh[LAST];
    end

    // R2
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ev.rise && ev.fall));
endmodule

// File: rtl/cmp_bank.sv
module cmp_bank #(
    parameter int W  = 16,
    parameter int CH = 2
) (
    input  logic [W-1:0]          count,
    input  logic [CH-1:0][W-1:0]  cmp,
    output logic [CH-1:0]         eq
);
    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign eq[i] = (count == cmp[i]);
    end
endmodule

// File: rtl/os_core.sv
module os_core
    import oneshot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_on,
    input  logic         start,
    input  logic         tick,
    input  logic         lo_hit,
    input  logic         hi_hit,
    input  logic [1:0]   eq,
    output logic [W-1:0] count,
    output logic         run,
    output logic         active,
    output logic [1:0]   match
);
    core_flags_t flags;

    always_ff @(posedge clk) begin
        if (rst || !mode_on) begin
            count <= '0;
            flags <= '0;
            match <= '0;
        end else begin
            match <= {2{flags.run & tick}} & eq;
            if (!flags.run) begin
                if (start) begin
                    count        <= '0;
                    flags.run    <= 1'b1;
                    flags.active <= 1'b0;
                end
            end else if (tick) begin
                if (hi_hit) begin
                    flags <= '0;
                end else begin
                    count <= count + 1'b1;
                    if (lo_hit) flags.active <= 1'b1;
                end
            end
        end
    end

    assign run    = flags.run;
    assign active = flags.active;

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && start && mode_on) |=> (run && count == '0));
    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_on |=> (!run && !active && count == '0));
    // R8
    lockout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && mode_on) |=> $stable(count));
    // R9
    end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && hi_hit && mode_on) |=> (!run && $stable(count)));
    // R10
    active_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> run);
    // R7
    match_a_single_chk: assert property (@(posedge clk) disable iff (rst)
        match[0] |=> !match[0]);
    // R7
    match_b_single_chk: assert property (@(posedge clk) disable iff (rst)
        match[1] |=> !match[1]);
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [1:0]       edge_sel,
    input  logic             sw_trig,
    input  logic             trig_in,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             idle_level,
    output logic             pulse_out,
    output logic             match_a,
    output logic             match_b,
    output logic             busy,
    output logic [CNT_W-1:0] count
);
    localparam int NCMP = 2;

    os_mode_e                    mode_q;
    edge_ev_t                    pin_ev;
    logic                        start;
    logic                        a_lower;
    logic [NCMP-1:0]             eq;
    logic [NCMP-1:0]             match;
    logic [NCMP-1:0][CNT_W-1:0]  cmp_vec;
    logic                        active;
    logic                        lo_hit, hi_hit;

    assign mode_q = os_mode_e'(mode);

    trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (trig_in),
        .ev  (pin_ev)
    );

    assign start = (pin_allowed(mode_q) & edge_hit(edge_sel, pin_ev))
                 | (soft_allowed(mode_q) & sw_trig);

    assign cmp_vec = {cmp_b, cmp_a};

    cmp_bank #(.W(CNT_W), .CH(NCMP)) u_cmp (
        .count (count),
        .cmp   (cmp_vec),
        .eq    (eq)
    );

    assign a_lower = (cmp_a < cmp_b);
    assign lo_hit  = a_lower ? eq[0] : eq[1];
    assign hi_hit  = a_lower ? eq[1] : eq[0];

    os_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .mode_on (mode_q != MODE_STOP),
        .start   (start),
        .tick    (cnt_en),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .eq      (eq),
        .count   (count),
        .run     (busy),
        .active  (active),
        .match   (match)
    );

    assign match_a   = match[0];
    assign match_b   = match[1];
    assign pulse_out = active ^ idle_level;

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pulse_out == idle_level));
endmodule

// File: tb/tb_pulse_timer.sv
module tb_pulse_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode, edge_sel;
    logic         sw_trig, trig_in, cnt_en, idle_level;
    logic [W-1:0] cmp_a, cmp_b;
    logic         pulse_out, match_a, match_b, busy;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pulse_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .mode(mode), .edge_sel(edge_sel),
        .sw_trig(sw_trig), .trig_in(trig_in), .cnt_en(cnt_en),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .idle_level(idle_level),
        .pulse_out(pulse_out), .match_a(match_a), .match_b(match_b),
        .busy(busy), .count(count)
    );

    // Reference model built from the requirements
    logic         m_s1, m_s2, m_s3, e_run, e_act, e_ma, e_mb;
    logic [W-1:0] e_cnt;

    function automatic logic [W-1:0] lo_of(input logic [W-1:0] a, b);
        return (a < b) ? a : b;
    endfunction
    function automatic logic [W-1:0] hi_of(input logic [W-1:0] a, b);
        return (a < b) ? b : a;
    endfunction

    always @(posedge clk) begin
        logic rise, fall, trg;
        rise = m_s2 & ~m_s3;
        fall = ~m_s2 & m_s3;
        trg  = (mode[0] & ((edge_sel[0] & rise) | (edge_sel[1] & fall)))
             | (mode[1] & sw_trig);
        if (rst) begin
            {m_s1, m_s2, m_s3} <= '0;
        end else begin
            m_s1 <= trig_in; m_s2 <= m_s1; m_s3 <= m_s2;
        end
        if (rst || mode == 2'b00) begin
            e_cnt <= '0; e_run <= 0; e_act <= 0; e_ma <= 0; e_mb <= 0;
        end else begin
            e_ma <= e_run & cnt_en & (e_cnt == cmp_a);
            e_mb <= e_run & cnt_en & (e_cnt == cmp_b);
            if (!e_run) begin
                if (trg) begin e_cnt <= '0; e_run <= 1; e_act <= 0; end
            end else if (cnt_en) begin
                if (e_cnt == hi_of(cmp_a, cmp_b)) begin
                    e_run <= 0; e_act <= 0;
                end else begin
                    e_cnt <= e_cnt + 1'b1;
                    if (e_cnt == lo_of(cmp_a, cmp_b)) e_act <= 1;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk(count == e_cnt, "R3 count", 32'(count), 32'(e_cnt));
        chk(busy == e_run, "R9 busy", 32'(busy), 32'(e_run));
        chk(pulse_out == (e_act ^ idle_level), "R5 pulse_out",
            32'(pulse_out), 32'(e_act ^ idle_level));
        chk(match_a == e_ma, "R7 match_a", 32'(match_a), 32'(e_ma));
        chk(match_b == e_mb, "R7 match_b", 32'(match_b), 32'(e_mb));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) cmp_all();
    endtask

    task automatic soft_pulse();
        sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    endtask

    task automatic run_until_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) tick();
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        rst = 1; mode = 2'b00; edge_sel = 2'b00; sw_trig = 0; trig_in = 0;
        cnt_en = 0; idle_level = 0; cmp_a = '0; cmp_b = 16'd1;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(count == 0 && !busy && !match_a && !match_b && pulse_out == idle_level,
            "R1 in reset", {count, 3'b0, busy, match_a, match_b, pulse_out}, 0);
        rst = 0;
        tick();
        chk(count == 0 && !busy && pulse_out == 1'b0, "R1 after reset",
            {count, 7'b0, busy}, 0);

        // Software trigger, a below b
        mode = 2'b10; cnt_en = 1; cmp_a = 16'd5; cmp_b = 16'd9;
        soft_pulse();
        chk(busy && count == 0, "R3 start", {count, 7'b0, busy}, 1);
        run_until_idle(50);
        chk(!busy && count == 16'd9, "R9 hold at end", 32'(count), 32'd9);
        tick();
        chk(count == 16'd9, "R9 still held", 32'(count), 32'd9);

        // Swapped order
        cmp_a = 16'd12; cmp_b = 16'd4;
        soft_pulse();
        run_until_idle(50);
        chk(!busy && count == 16'd12, "R6 swapped end", 32'(count), 32'd12);

        // Pin trigger latency, rising edge
        mode = 2'b01; edge_sel = 2'b01; cmp_a = 3; cmp_b = 8;
        repeat (3) tick();
        trig_in = 1;
        tick(); tick();
        chk(!busy, "R2 not before third edge", 32'(busy), 0);
        tick();
        chk(busy, "R2 busy after third edge", 32'(busy), 1);
        run_until_idle(50);
        // Falling edge not accepted with edge_sel 01
        trig_in = 0;
        repeat (5) tick();
        chk(!busy && count == 8, "R2 falling ignored", 32'(busy), 0);
        // Falling accepted with 10
        edge_sel = 2'b10; trig_in = 1; repeat (4) tick();
        trig_in = 0; repeat (3) tick();
        chk(busy, "R2 falling accepted", 32'(busy), 1);
        run_until_idle(50);

        // Software strobe ignored in pin-only mode
        soft_pulse(); tick();
        chk(!busy, "R4 soft ignored in pin mode", 32'(busy), 0);

        // Lockout
        mode = 2'b11; edge_sel = 2'b11; cmp_a = 3; cmp_b = 30;
        soft_pulse();
        repeat (5) tick();
        soft_pulse();
        trig_in = 1;
        repeat (3) tick();
        chk(busy && count == 16'd9, "R8 retrigger ignored", 32'(count), 32'd9);
        // Stop in mid-pulse
        mode = 2'b00; tick();
        chk(!busy && count == 0 && pulse_out == idle_level, "R4 stop clears",
            32'(count), 0);
        trig_in = 0;

        // Active-low pulse
        mode = 2'b10; idle_level = 1; cmp_a = 2; cmp_b = 6;
        tick();
        chk(pulse_out == 1'b1, "R10 idle high", 32'(pulse_out), 1);
        soft_pulse(); repeat (4) tick();
        chk(pulse_out == 1'b0, "R10 active low", 32'(pulse_out), 0);
        run_until_idle(20);
        idle_level = 0;

        // Full-range pulse
        cmp_a = 16'd0; cmp_b = 16'hFFFF;
        soft_pulse();
        run_until_idle(70000);
        chk(!busy && count == 16'hFFFF, "R9 top value", 32'(count), 32'hFFFF);

        // Random episodes
        for (int ep = 0; ep < 300; ep++) begin
            mode     = 2'(1 + ($urandom % 3));
            edge_sel = 2'($urandom % 4);
            idle_level = 1'($urandom % 2);
            cmp_a = 16'($urandom % 40);
            do cmp_b = 16'($urandom % 40); while (cmp_b == cmp_a);
            for (int c = 0; c < 80; c++) begin
                cnt_en  = ($urandom % 4) != 0;
                sw_trig = ($urandom % 16) == 0;
                if (($urandom % 8) == 0) trig_in = ~trig_in;
                if (($urandom % 200) == 0) mode = 2'b00;
                tick();
            end
            sw_trig = 0;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule